// File: doc/BRIEF.md
# Time Base Interval Timer with Watchdog

The block runs a free 21-bit time base counter that advances once for every two enabled clock cycles. A carry out of a chosen low part of that counter marks an interval event. Four intervals can be picked, and the interval flag is raised at each event of the chosen interval. The flag stays high until software acknowledges it.

On top of the same chain sits a watchdog. Once software starts it, the watchdog counts ticks from a fixed carry position of the time base, or, when selected, rising edges of a square wave from a slow sub-clock prescaler. The watchdog gives a one-cycle reset pulse on the second tick after the last clear, so a clear must come within one to two tick periods. After it starts, only a reset stops it. The oscillator and the standby logic are outside this block. A scale parameter moves every carry position down by the same amount, so that short runs can reach the long intervals.

Top module: `tbase_wdog`

## Requirements
- R1: While reset is held and right after it, both `irq_flag` and `wd_reset` are low.
- R2: The counter advances on every second enabled cycle. Let P be the carry position for the select code `ivl_sel`, after SCALE is subtracted: code 0 is 13, code 1 is 15, code 2 is 18 and code 3 is 21. The first `irq_flag` rise follows clock edge 2^(P+1), counted from reset release.
- R3: Interval events repeat every 2^(P+1) enabled cycles.
- R4: `irq_flag` stays high until `irq_ack` is high at a clock edge. It is low after that edge.
- R5: An interval event and an acknowledge at the same edge leave `irq_flag` set.
- R6: While `tb_en` is low, the time base does not move. Each disabled cycle delays later events by one cycle.
- R7: Until `wd_start` has been seen high, `wd_reset` never pulses.
- R8: Once started, with no clear, `wd_reset` pulses for exactly one cycle on every second tick. `wd_start` going low again does not stop the watchdog.
- R9: `wd_clear` zeroes the watchdog count, so the pulse comes on the second tick after the clear. A clear at the same edge as a tick wins, and that tick is lost.
- R10: With `wd_src` = 0, the watchdog ticks on carries into position 20 minus SCALE, that is, every 2^(21-SCALE) enabled cycles.
- R11: With `wd_src` = 1, the watchdog ticks on each rising edge of `sub_tap`, and time base carries have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_en | input | 1 | Time base count enable |
| ivl_sel | input | 2 | Interval select code, 0 to 3 |
| irq_ack | input | 1 | Clears the interval flag |
| wd_start | input | 1 | Starts the watchdog, which stays on until reset |
| wd_clear | input | 1 | Zeroes the watchdog count |
| wd_src | input | 1 | Watchdog tick source: 0 time base, 1 sub-clock tap |
| sub_tap | input | 1 | Square wave from the sub-clock prescaler |
| irq_flag | output | 1 | Interval interrupt flag |
| wd_reset | output | 1 | One-cycle watchdog reset pulse |

## Verification
A wrong time base count shows up as an interval flag rise on the wrong edge. The bench checks this on the first event of every select code, so the error shows within one interval period. A wrong watchdog count or a lost clear moves the reset pulse by a whole tick period. Clearing just after a tick, just before a tick and on a tick separates these cases within three tick periods. A wrong source choice shows as a pulse, or a missing pulse, when the bench drives only the other source.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  localparam int NUM_IVL     = 4;
  localparam int WD_BASE_POS = 20;

  typedef enum logic {WD_SRC_MAIN = 1'b0, WD_SRC_SUB = 1'b1} wd_src_e;

  // Unscaled carry position of each interval select code.
  function automatic int ivl_base_pos(input int idx);
    int r;
    case (idx)
      0:       r = 13;
      1:       r = 15;
      2:       r = 18;
      default: r = 21;
    endcase
    return r;
  endfunction

  // Move a carry position down by the scale amount, never below 1.
  function automatic int scaled_pos(input int base, input int scale);
    int r;
    r = base - scale;
    if (r < 1) r = 1;
    return r;
  endfunction
endpackage

// File: rtl/tbw_prescale.sv
module tbw_prescale #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic             adv,
  output logic [CNT_W-1:0] cnt
);
  logic phase;

  assign adv = en & phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      cnt   <= '0;
    end else if (en) begin
      phase <= ~phase;
      if (phase) cnt <= cnt + 1'b1;
    end
  end

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |=> $stable(cnt));
  // R2
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n) adv |=> !adv);
endmodule

// File: rtl/tbw_taps.sv
module tbw_taps
  import tbw_pkg::*;
#(
  parameter int CNT_W = 21,
  parameter int SCALE = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               adv,
  output logic [NUM_IVL-1:0] ivl_hit,
  output logic               wd_hit
);
  localparam int WD_POS = scaled_pos(WD_BASE_POS, SCALE);

  // True when the low pos bits are all ones, so the next advance carries into pos.
  function automatic logic low_full(input logic [CNT_W-1:0] c, input int pos);
    logic full;
    full = 1'b1;
    for (int i = 0; i < CNT_W; i++)
      if (i < pos && !c[i]) full = 1'b0;
    return full;
  endfunction

  for (genvar g = 0; g < NUM_IVL; g++) begin : g_ivl
    localparam int POS = scaled_pos(ivl_base_pos(g), SCALE);
    assign ivl_hit[g] = adv & low_full(cnt, POS);
  end

  assign wd_hit = adv & low_full(cnt, WD_POS);

  // R3
  nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_hit[NUM_IVL-1] |-> (&ivl_hit));
endmodule

// File: rtl/tbw_irq.sv
module tbw_irq
  import tbw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IVL-1:0] ivl_hit,
  input  logic [1:0]         sel,
  input  logic               ack,
  output logic               flag
);
  logic evt;

  assign evt = ivl_hit[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (evt) flag <= 1'b1;
    else if (ack) flag <= 1'b0;
  end

  // R2
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag) |-> $past(evt));
  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(flag) |-> $past(ack));
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n) evt |=> flag);
endmodule

// File: rtl/tbw_guard.sv
module tbw_guard
  import tbw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    clear,
  input  wd_src_e src,
  input  logic    main_hit,
  input  logic    sub_lvl,
  output logic    pulse
);
  logic       armed;
  logic       sub_q;
  logic       sub_rise;
  logic       tick;
  logic       expire;
  logic [1:0] wcnt;

  // Next count: a clear or an expiry returns to zero, a tick adds one.
  function automatic logic [1:0] wd_next(input logic [1:0] c, input logic t,
                                         input logic clr, input logic exp_now);
    logic [1:0] r;
    if (clr || exp_now) r = 2'd0;
    else if (t)         r = c + 2'd1;
    else                r = c;
    return r;
  endfunction

  assign sub_rise = sub_lvl & ~sub_q;
  assign tick     = armed & ((src == WD_SRC_SUB) ? sub_rise : main_hit);
  assign expire   = tick & ~clear & (wcnt == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      sub_q <= 1'b0;
      wcnt  <= 2'd0;
      pulse <= 1'b0;
    end else begin
      sub_q <= sub_lvl;
      if (start) armed <= 1'b1;
      wcnt  <= wd_next(wcnt, tick, clear, expire);
      pulse <= expire;
    end
  end

  // R8
  armed_stays_chk: assert property (@(posedge clk) disable iff (!rst_n) armed |=> armed);
  // R8
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n) pulse |=> !pulse);
  // R7
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n) pulse |-> $past(armed));
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n) clear |=> !pulse);
  // R11
  sub_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == WD_SRC_SUB && !sub_rise) |=> !pulse);
endmodule

// File: rtl/tbase_wdog.sv
module tbase_wdog
  import tbw_pkg::*;
#(
  parameter int CNT_W = 21,
  parameter int SCALE = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tb_en,
  input  logic [1:0] ivl_sel,
  input  logic       irq_ack,
  input  logic       wd_start,
  input  logic       wd_clear,
  input  logic       wd_src,
  input  logic       sub_tap,
  output logic       irq_flag,
  output logic       wd_reset
);
  logic               adv;
  logic [CNT_W-1:0]   cnt;
  logic [NUM_IVL-1:0] ivl_hit;
  logic               wd_hit;

  tbw_prescale #(.CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(tb_en), .adv(adv), .cnt(cnt)
  );

  tbw_taps #(.CNT_W(CNT_W), .SCALE(SCALE)) u_taps (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .adv(adv),
    .ivl_hit(ivl_hit), .wd_hit(wd_hit)
  );

  tbw_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ivl_hit(ivl_hit), .sel(ivl_sel),
    .ack(irq_ack), .flag(irq_flag)
  );

  tbw_guard u_guard (
    .clk(clk), .rst_n(rst_n), .start(wd_start), .clear(wd_clear),
    .src(wd_src_e'(wd_src)), .main_hit(wd_hit), .sub_lvl(sub_tap),
    .pulse(wd_reset)
  );
endmodule

// File: tb/tb_tbase_wdog.sv
module tb_tbase_wdog;
  localparam int SC = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic tb_en, irq_ack, wd_start, wd_clear, wd_src, sub_tap;
  logic [1:0] ivl_sel;
  logic irq_flag, wd_reset;

  int checks = 0;
  int errors = 0;
  int tk = 0;
  int irq_first, irq_hi, wd_first, wd_second, wd_hi;

  always #5 clk = ~clk;

  tbase_wdog #(.CNT_W(21), .SCALE(SC)) dut (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .ivl_sel(ivl_sel),
    .irq_ack(irq_ack), .wd_start(wd_start), .wd_clear(wd_clear),
    .wd_src(wd_src), .sub_tap(sub_tap), .irq_flag(irq_flag), .wd_reset(wd_reset)
  );

  function automatic int ivl_period(input int code);
    int base;
    base = (code == 0) ? 13 : (code == 1) ? 15 : (code == 2) ? 18 : 21;
    return 1 << (base - SC + 1);
  endfunction

  localparam int WD_PER = 1 << (21 - SC);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    tk++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tb_en = 1'b0; irq_ack = 1'b0; wd_start = 1'b0;
    wd_clear = 1'b0; wd_src = 1'b0; sub_tap = 1'b0; ivl_sel = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tk = 0;
  endtask

  task automatic run_scan(input int upto, input int clear_at);
    irq_first = -1; irq_hi = 0; wd_first = -1; wd_second = -1; wd_hi = 0;
    while (tk < upto) begin
      wd_clear = (tk + 1 == clear_at);
      step();
      if (irq_flag) begin
        irq_hi++;
        if (irq_first < 0) irq_first = tk;
      end
      if (wd_reset) begin
        wd_hi++;
        if (wd_first < 0) wd_first = tk;
        else if (wd_second < 0) wd_second = tk;
      end
    end
    wd_clear = 1'b0;
  endtask

  task automatic start_wd();
    wd_start = 1'b1;
    step();
    wd_start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    rst_n = 1'b0; tb_en = 1'b0; irq_ack = 1'b0; wd_start = 1'b0;
    wd_clear = 1'b0; wd_src = 1'b0; sub_tap = 1'b0; ivl_sel = 2'd0;
    @(negedge clk);
    check(irq_flag == 1'b0 && wd_reset == 1'b0, "R1 outputs in reset", {irq_flag, wd_reset}, 0);
    do_reset();
    step();
    check(irq_flag == 1'b0 && wd_reset == 1'b0, "R1 outputs after release", {irq_flag, wd_reset}, 0);

    // R2 R3 R4 sweep over every select code
    for (int s = 0; s < 4; s++) begin
      int per;
      int first;
      per = ivl_period(s);
      do_reset();
      ivl_sel = 2'(s); tb_en = 1'b1;
      run_scan(per, 0);
      check(irq_first == per, "R2 first interval event", irq_first, per);
      first = tk;
      run_scan(first + 3, 0);
      check(irq_flag == 1'b1, "R4 flag held without ack", irq_flag, 1);
      irq_ack = 1'b1; step(); irq_ack = 1'b0;
      check(irq_flag == 1'b0, "R4 flag cleared by ack", irq_flag, 0);
      run_scan(2 * per, 0);
      check(irq_first == 2 * per, "R3 repeat period", irq_first, 2 * per);
    end

    // R5 ack held high: flag still sets for one cycle per event
    do_reset();
    tb_en = 1'b1; irq_ack = 1'b1;
    run_scan(4 * ivl_period(0), 0);
    check(irq_hi == 4, "R5 set wins over ack", irq_hi, 4);
    irq_ack = 1'b0;

    // R6 disabled cycles delay the event
    do_reset();
    tb_en = 1'b1;
    repeat (5) step();
    tb_en = 1'b0;
    repeat (7) step();
    tb_en = 1'b1;
    run_scan(ivl_period(0) + 10, 0);
    check(irq_first == ivl_period(0) + 7, "R6 enable freeze", irq_first, ivl_period(0) + 7);

    // R7 not started: no pulse
    do_reset();
    tb_en = 1'b1;
    run_scan(3 * WD_PER, 0);
    check(wd_hi == 0, "R7 idle watchdog", wd_hi, 0);

    // R8 R10 started, never cleared
    do_reset();
    tb_en = 1'b1;
    start_wd();
    run_scan(4 * WD_PER + 5, 0);
    check(wd_first == 2 * WD_PER, "R10 first timeout on time base", wd_first, 2 * WD_PER);
    check(wd_second == 4 * WD_PER, "R8 keeps running after pulse", wd_second, 4 * WD_PER);
    check(wd_hi == 2, "R8 one-cycle pulses", wd_hi, 2);

    // R9 clear just after a tick, just before a tick, and on a tick
    for (int c = 0; c < 3; c++) begin
      int cat;
      int exp;
      cat = (c == 0) ? WD_PER + 2 : (c == 1) ? 2 * WD_PER - 1 : 2 * WD_PER;
      exp = (c == 2) ? 4 * WD_PER : 3 * WD_PER;
      do_reset();
      tb_en = 1'b1;
      start_wd();
      run_scan(4 * WD_PER + 5, cat);
      check(wd_first == exp, "R9 timeout after clear", wd_first, exp);
    end

    // R11 sub-clock source
    do_reset();
    tb_en = 1'b1; wd_src = 1'b1;
    start_wd();
    run_scan(100, 0);
    sub_tap = 1'b1;
    run_scan(110, 0);
    sub_tap = 1'b0;
    run_scan(2 * WD_PER + 10, 0);
    check(wd_hi == 0, "R11 time base ignored on sub source", wd_hi, 0);
    sub_tap = 1'b1;
    step();
    check(wd_reset == 1'b1, "R11 pulse on second sub edge", wd_reset, 1);
    step();
    check(wd_reset == 1'b0, "R11 pulse ends", wd_reset, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule